// File: doc/BRIEF.md
# Serial PLL Register Loader

This block brings up a frequency synthesizer chip through a three-wire serial port made of a serial clock, a data line and a load strobe. After reset it waits out a start-up interval, then sends four 21-bit configuration words, each closed by a strobe pulse that moves the word into the addressed latch inside the chip. A settle interval follows each strobe. The serial clock is a divided copy of the system clock, and every delay is counted in system clock cycles derived from a clock-frequency parameter.

The last word carries the main divide ratio N. The block splits N into the program count B = N div 32 and the swallow count A = N mod 32 for the chip's dual-modulus prescaler. A channel input chooses one of two preset N values. When that input changes after bring-up, only the main-divider word is sent again. The chip's lock-detect pin is passed through a two-flop synchronizer to a status output.

Top module: `pll_word_loader`

## Requirements
- R1: Each word is 21 bits, most significant bit first. `ser_data` changes only while `ser_clk` is low, and each bit is followed by one rising edge of `ser_clk`. Exactly 21 rising edges come before each strobe.
- R2: After the 21st bit, `ser_le` goes high for SCLK_HALF system cycles and then low. `ser_clk` is low whenever `ser_le` is high.
- R3: Words are sent in a fixed order. The first word is 0x00093 (control bits 11) and the second is 0x00092 (control bits 10). The third is R_DIV shifted left by two with control bits 00, which is 0x000A0 for R_DIV = 40. The main-divider word comes last.
- R4: The main-divider word has bit 20 set, B = N div 32 in bits 19..7, A = N mod 32 in bits 6..2, and control bits 01.
- R5: With `chan_sel` high, N = N_HI (8370, word 0x1082C9). With `chan_sel` low, N = N_LO (10000, word 0x109C41).
- R6: No rising edge of `ser_clk` occurs before at least CLK_HZ*START_MS/1000 system cycles have passed since reset was released.
- R7: After each strobe falls, at least CLK_HZ*SETTLE_MS/1000 system cycles pass before the next rising edge of `ser_clk`.
- R8: After the fourth word and its settle time, `done` goes high and `ser_clk`, `ser_data` and `ser_le` all stay low.
- R9: A change of the synchronized `chan_sel` while `done` is high drops `done` and sends only the main-divider word for the new channel. `done` returns high after that word's settle time.
- R10: `locked` equals `lock_in` delayed by two system clock cycles. Low means unlocked.
- R11: While reset is held, `ser_clk`, `ser_data`, `ser_le`, `done` and `locked` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 1 | Channel choice: high selects N_HI, low selects N_LO |
| lock_in | input | 1 | Lock-detect pin from the synthesizer chip |
| ser_clk | output | 1 | Serial clock to the chip |
| ser_data | output | 1 | Serial data to the chip |
| ser_le | output | 1 | Load strobe to the chip |
| done | output | 1 | Configuration complete and lines idle |
| locked | output | 1 | Synchronized lock status |

## Verification
The bench builds the block with CLK_HZ = 1000, a start-up time of 20 ms and a settle time of 3 ms. This shrinks the intervals to 20 and 3 cycles, so SCLK_HALF = 2 makes one full load last only a few hundred cycles. At that size the bench decodes every serial bit of every word from the pins. It checks each full sequence for both channels, both directions of a channel change after bring-up, and the minimum start-up and settle gaps, with every expected word computed from the N split in the bench.

// File: rtl/pll_word_loader.sv
module pll_word_loader #(
  parameter int CLK_HZ     = 200_000_000,
  parameter int START_MS   = 20,
  parameter int SETTLE_MS  = 3,
  parameter int SCLK_HALF  = 50,
  parameter int R_DIV      = 40,
  parameter int N_HI       = 8370,
  parameter int N_LO       = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_sel,
  input  logic lock_in,
  output logic ser_clk,
  output logic ser_data,
  output logic ser_le,
  output logic done,
  output logic locked
);

  localparam int W          = 21;
  localparam int START_CYC  = (CLK_HZ / 1000 * START_MS  > 0) ? CLK_HZ / 1000 * START_MS  : 1;
  localparam int SETTLE_CYC = (CLK_HZ / 1000 * SETTLE_MS > 0) ? CLK_HZ / 1000 * SETTLE_MS : 1;
  localparam int HALF_CYC   = (SCLK_HALF > 0) ? SCLK_HALF : 1;

  localparam logic [W-1:0] INIT_WORD = 21'h00093;
  localparam logic [W-1:0] FUNC_WORD = 21'h00092;
  localparam logic [W-1:0] REF_WORD  = {5'd0, 14'(R_DIV), 2'b00};
  localparam logic [W-1:0] MAIN_HI   = {1'b1, 13'(N_HI / 32), 5'(N_HI % 32), 2'b01};
  localparam logic [W-1:0] MAIN_LO   = {1'b1, 13'(N_LO / 32), 5'(N_LO % 32), 2'b01};

  typedef enum logic [2:0] {S_BOOT, S_SHIFT, S_LE, S_SETTLE, S_IDLE} state_t;

  state_t        state;
  logic [31:0]   cnt;
  logic [1:0]    widx;
  logic [4:0]    bidx;
  logic          hi_phase;
  logic [W-1:0]  sh;
  logic          sclk_q, le_q, done_q, ch_used;
  logic [1:0]    ch_sync, lk_sync;

  wire ch_s = ch_sync[1];

  function automatic logic [W-1:0] pick_word(input logic [1:0] idx, input logic ch);
    case (idx)
      2'd0:    pick_word = INIT_WORD;
      2'd1:    pick_word = FUNC_WORD;
      2'd2:    pick_word = REF_WORD;
      default: pick_word = ch ? MAIN_HI : MAIN_LO;
    endcase
  endfunction

  assign ser_clk  = sclk_q;
  assign ser_le   = le_q;
  assign ser_data = (state == S_SHIFT) ? sh[W-1] : 1'b0;
  assign done     = done_q;
  assign locked   = lk_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_sync <= '0;
      lk_sync <= '0;
    end else begin
      ch_sync <= {ch_sync[0], chan_sel};
      lk_sync <= {lk_sync[0], lock_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_BOOT;
      cnt      <= '0;
      widx     <= '0;
      bidx     <= '0;
      hi_phase <= 1'b0;
      sh       <= '0;
      sclk_q   <= 1'b0;
      le_q     <= 1'b0;
      done_q   <= 1'b0;
      ch_used  <= 1'b0;
    end else begin
      case (state)
        S_BOOT: begin
          if (cnt == 32'(START_CYC - 1)) begin
            cnt      <= '0;
            widx     <= 2'd0;
            sh       <= pick_word(2'd0, ch_s);
            bidx     <= 5'(W - 1);
            hi_phase <= 1'b0;
            state    <= S_SHIFT;
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        S_SHIFT: begin
          if (cnt == 32'(HALF_CYC - 1)) begin
            cnt <= '0;
            if (!hi_phase) begin
              sclk_q   <= 1'b1;
              hi_phase <= 1'b1;
            end else begin
              sclk_q   <= 1'b0;
              hi_phase <= 1'b0;
              if (bidx == 5'd0) begin
                le_q  <= 1'b1;
                state <= S_LE;
              end else begin
                sh   <= {sh[W-2:0], 1'b0};
                bidx <= bidx - 5'd1;
              end
            end
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        S_LE: begin
          if (cnt == 32'(HALF_CYC - 1)) begin
            cnt   <= '0;
            le_q  <= 1'b0;
            state <= S_SETTLE;
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        S_SETTLE: begin
          if (cnt == 32'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            if (widx == 2'd3) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              widx     <= widx + 2'd1;
              sh       <= pick_word(widx + 2'd1, ch_s);
              if (widx == 2'd2) ch_used <= ch_s;
              bidx     <= 5'(W - 1);
              hi_phase <= 1'b0;
              state    <= S_SHIFT;
            end
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        default: begin
          if (ch_s != ch_used) begin
            done_q   <= 1'b0;
            ch_used  <= ch_s;
            widx     <= 2'd3;
            sh       <= pick_word(2'd3, ch_s);
            bidx     <= 5'(W - 1);
            hi_phase <= 1'b0;
            cnt      <= '0;
            state    <= S_SHIFT;
          end
        end
      endcase
    end
  end

  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R2
  le_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_clk && !ser_le && !ser_data));

  // R9
  reload_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (state == S_IDLE && widx == 2'd3));

  // R10
  lock_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> $past(lock_in, 2));

endmodule

// File: tb/pll_word_loader_bench.sv
module pll_word_loader_bench;
  localparam int START_CYC  = 20;
  localparam int SETTLE_CYC = 3;
  localparam int NH = 8370;
  localparam int NL = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_sel = 1'b1;
  logic lock_in = 1'b0;
  logic ser_clk, ser_data, ser_le, done, locked;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pll_word_loader #(
    .CLK_HZ(1000), .START_MS(20), .SETTLE_MS(3), .SCLK_HALF(2),
    .R_DIV(40), .N_HI(NH), .N_LO(NL)
  ) u_pll_word_loader (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .lock_in(lock_in),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .done(done), .locked(locked)
  );

  logic [20:0] words [0:7];
  int bitcnt [0:7];
  int wcount = 0;
  logic [20:0] cap = '0;
  int nbits = 0;
  logic p_clk = 1'b0, p_le = 1'b0;
  int cyc = 0, first_rise = -1, gap = 0, min_gap = 1000000;
  bit gap_on = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; first_rise = -1; p_clk = 0; p_le = 0; gap_on = 0;
    end else begin
      cyc++;
      if (gap_on) gap++;
      if (ser_clk && !p_clk) begin
        cap = {cap[19:0], ser_data};
        nbits++;
        if (first_rise < 0) first_rise = cyc;
        if (gap_on) begin
          if (gap < min_gap) min_gap = gap;
          gap_on = 0;
        end
      end
      if (ser_le && !p_le && wcount < 8) begin
        words[wcount] = cap;
        bitcnt[wcount] = nbits;
        wcount++;
        nbits = 0;
      end
      if (!ser_le && p_le) begin
        gap = 0; gap_on = 1;
      end
      p_clk = ser_clk; p_le = ser_le;
    end
  end

  function automatic logic [20:0] main_word(input int n);
    return 21'((1 << 20) | ((n / 32) << 7) | ((n % 32) << 2) | 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
  endtask

  task automatic full_run(input logic ch);
    rst_n = 0; chan_sel = ch; lock_in = 1;
    repeat (4) @(negedge clk);
    // R11
    chk("R11 lines", {ser_clk, ser_data, ser_le}, 0);
    chk("R11 done", done, 0);
    chk("R11 locked", locked, 0);
    wcount = 0; nbits = 0; min_gap = 1000000;
    lock_in = 0;
    rst_n = 1;
    wait_done();
    chk("R8 done", done, 1);
    chk("R3 count", wcount, 4);
    chk("R3 init", words[0], 21'h00093);
    chk("R3 func", words[1], 21'h00092);
    chk("R3 ref", words[2], 21'(40 << 2));
    // R4 R5
    chk("R4/R5 main", words[3], main_word(ch ? NH : NL));
    for (int k = 0; k < 4; k++) chk("R1 bits", bitcnt[k], 21);
    chk("R6 start", first_rise >= START_CYC, 1);
    chk("R7 settle", min_gap >= SETTLE_CYC, 1);
    repeat (10) @(negedge clk);
    chk("R8 idle", {ser_clk, ser_data, ser_le, done}, 4'b0001);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    full_run(1'b1);
    chk("R5 hi literal", main_word(NH), 21'h1082C9);
    chk("R5 lo literal", main_word(NL), 21'h109C41);

    // R10 both edges
    for (int v = 1; v >= 0; v--) begin
      lock_in = v[0];
      @(negedge clk); chk("R10 one cycle", locked, !v[0]);
      @(negedge clk); chk("R10 two cycles", locked, v[0]);
    end

    // R9 channel change reloads only main word, both directions
    for (int s = 0; s < 2; s++) begin
      logic nc;
      nc = (s == 0) ? 1'b0 : 1'b1;
      min_gap = 1000000;
      chan_sel = nc;
      repeat (4) @(negedge clk);
      chk("R9 done drops", done, 0);
      wait_done();
      chk("R9 count", wcount, 5 + s);
      chk("R9 main", words[4 + s], main_word(nc ? NH : NL));
      chk("R9 bits", bitcnt[4 + s], 21);
      chk("R7 reload settle", min_gap >= SETTLE_CYC, 1);
      repeat (5) @(negedge clk);
      chk("R8 idle after reload", {ser_clk, ser_data, ser_le, done}, 4'b0001);
    end

    // R9 no change, no activity
    repeat (50) @(negedge clk);
    chk("R9 no reload", wcount, 6);

    full_run(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule